// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Arbiter

Several devices share one interrupt request line. Each device raises its request with a single-cycle pulse, and the request stays pending inside its slot until it is served. The shared request output is the OR of all pending slots. That line tells the processor that some device wants service, but not which one.

When the processor answers with a one-cycle acknowledge pulse, the acknowledge enters the chain at slot 0, the slot nearest the processor. A slot with no pending request passes it to the next slot. The first pending slot absorbs it and passes nothing further down the chain. On the next clock edge the block registers the following outputs:
- the winner's configured vector number, with a valid pulse;
- a one-hot grant showing which slot won;
- the handler-table address, which is the vector multiplied by four.

If no slot takes the acknowledge, it falls off the end of the chain and the block flags a spurious interrupt instead.

Top module: `irq_chain_arb`

## Requirements
- R1: One cycle after any device raise pulse, `intReq` is high. It stays high while any slot is still pending.
- R2: One cycle after an `intAck` pulse, `devGranted` is one-hot at the lowest-index pending slot. Slot 0 has the highest priority.
- R3: A grant clears only the winning slot's pending request. The other pending slots stay pending, so `intReq` stays high while any remain.
- R4: One cycle after an acknowledge that finds a pending slot, `vecValid` pulses high and `vecData` equals the winner's configured vector. Slot i's vector is `SLOT_VECS[i*VEC_W +: VEC_W]`.
- R5: In the same cycle, `tableAddr` equals the winner's vector times 4, as a `VEC_W+2`-bit value (the vector followed by two zero bits).
- R6: An acknowledge that arrives while no slot is pending gives `spurious` high for one cycle, with `vecValid` low and `devGranted` zero. `vecData` and `tableAddr` keep their previous values.
- R7: A raise pulse on a slot in the same cycle as that slot's own grant leaves the slot pending. The new request is then served by a later acknowledge.
- R8: In any cycle that does not directly follow an acknowledge, `vecValid`, `spurious` and `devGranted` are low or zero, and `vecData` and `tableAddr` hold their values.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devRaise | input | NUM_DEV | One-cycle request pulse per slot |
| intAck | input | 1 | One-cycle acknowledge pulse from the processor |
| intReq | output | 1 | Shared request, the OR of the pending slots |
| vecData | output | VEC_W | Vector number of the last winner |
| vecValid | output | 1 | Pulse: vecData was just loaded |
| tableAddr | output | VEC_W+2 | Handler-table address, vector times 4 |
| spurious | output | 1 | Pulse: the acknowledge found no pending slot |
| devGranted | output | NUM_DEV | One-hot pulse marking the winning slot |

## Verification
A raise pulse becomes visible on `intReq` one cycle later, because it passes through one pending register. The acknowledge results (`vecValid`, `vecData`, `tableAddr`, `spurious`, `devGranted`) are also due one cycle after the acknowledge. The pending slot is cleared at that same edge, so `intReq` already reflects the grant in the cycle that follows.

The bench drives every input at the falling edge and samples at the next falling edge. Each check therefore lands exactly one rising edge after its stimulus. Hold checks are made one further cycle later, with no acknowledge in between.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int ADDR_SHIFT = 2;

  typedef struct packed {
    logic hit;
    logic miss;
  } arbStrobe_t;
endpackage

// File: rtl/irq_chain_slot.sv
module irq_chain_slot (
  input  logic ackIn,
  input  logic pending,
  output logic ackOut,
  output logic win
);
  assign win    = ackIn & pending;
  assign ackOut = ackIn & ~pending;
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
#(
  parameter int NUM_DEV = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devRaise,
  input  logic               intAck,
  output logic [NUM_DEV-1:0] pending,
  output logic [NUM_DEV-1:0] winVec,
  output arbStrobe_t         strobe
);
  logic [NUM_DEV:0] ackChain;

  assign ackChain[0] = intAck;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_slot
    irq_chain_slot u_slot (
      .ackIn  (ackChain[i]),
      .pending(pending[i]),
      .ackOut (ackChain[i+1]),
      .win    (winVec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~winVec) | devRaise;
  end

  always_comb begin
    strobe.hit  = |winVec;
    strobe.miss = ackChain[NUM_DEV];
  end
endmodule

// File: rtl/irq_chain_dp.sv
module irq_chain_dp
  import irq_chain_pkg::*;
#(
  parameter int                       NUM_DEV   = 8,
  parameter int                       VEC_W     = 8,
  parameter logic [NUM_DEV*VEC_W-1:0] SLOT_VECS = '0,
  localparam int                      ADDR_W    = VEC_W + ADDR_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbStrobe_t         strobe,
  input  logic [NUM_DEV-1:0] winVec,
  output logic [VEC_W-1:0]   vecData,
  output logic [ADDR_W-1:0]  tableAddr,
  output logic               vecValid,
  output logic               spurious,
  output logic [NUM_DEV-1:0] devGranted
);
  logic [VEC_W-1:0] selVec;

  always_comb begin
    selVec = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (winVec[i]) selVec = selVec | SLOT_VECS[i*VEC_W +: VEC_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecData    <= '0;
      tableAddr  <= '0;
      vecValid   <= 1'b0;
      spurious   <= 1'b0;
      devGranted <= '0;
    end else begin
      if (strobe.hit) begin
        vecData   <= selVec;
        tableAddr <= {selVec, {ADDR_SHIFT{1'b0}}};
      end
      vecValid   <= strobe.hit;
      spurious   <= strobe.miss;
      devGranted <= winVec;
    end
  end
endmodule

// File: rtl/irq_chain_arb.sv
module irq_chain_arb
  import irq_chain_pkg::*;
#(
  parameter int                       NUM_DEV   = 8,
  parameter int                       VEC_W     = 8,
  parameter logic [NUM_DEV*VEC_W-1:0] SLOT_VECS =
    {8'hFF, 8'h6A, 8'h55, 8'h40, 8'h33, 8'h21, 8'h12, 8'h05},
  localparam int                      ADDR_W    = VEC_W + ADDR_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devRaise,
  input  logic               intAck,
  output logic               intReq,
  output logic [VEC_W-1:0]   vecData,
  output logic               vecValid,
  output logic [ADDR_W-1:0]  tableAddr,
  output logic               spurious,
  output logic [NUM_DEV-1:0] devGranted
);
  logic [NUM_DEV-1:0] pending;
  logic [NUM_DEV-1:0] winVec;
  arbStrobe_t         strobe;

  irq_chain_ctrl #(.NUM_DEV(NUM_DEV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .devRaise(devRaise),
    .intAck  (intAck),
    .pending (pending),
    .winVec  (winVec),
    .strobe  (strobe)
  );

  irq_chain_dp #(
    .NUM_DEV  (NUM_DEV),
    .VEC_W    (VEC_W),
    .SLOT_VECS(SLOT_VECS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .winVec    (winVec),
    .vecData   (vecData),
    .tableAddr (tableAddr),
    .vecValid  (vecValid),
    .spurious  (spurious),
    .devGranted(devGranted)
  );

  assign intReq = |pending;
endmodule

// File: rtl/irq_chain_arb_chk.sv
module irq_chain_arb_chk #(
  parameter int NUM_DEV = 8,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_DEV-1:0] devRaise,
  input logic               intAck,
  input logic               intReq,
  input logic [VEC_W-1:0]   vecData,
  input logic               vecValid,
  input logic [VEC_W+1:0]   tableAddr,
  input logic               spurious,
  input logic [NUM_DEV-1:0] devGranted
);
  a_r1_req_after_raise: assert property (@(posedge clk) disable iff (!rstN)
    (|devRaise) |=> intReq);

  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devGranted));

  a_r4_ack_gives_vector: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq) |=> (vecValid && !spurious));

  a_r5_addr_matches: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (tableAddr == {vecData, 2'b00}));

  a_r6_spurious_on_empty: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intReq) |=> (spurious && !vecValid && devGranted == '0));

  a_r8_valid_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid || spurious) |-> $past(intAck));

  a_r8_hold_without_ack: assert property (@(posedge clk) disable iff (!rstN)
    !$past(intAck) |-> ($stable(vecData) && $stable(tableAddr)));
endmodule

bind irq_chain_arb irq_chain_arb_chk #(.NUM_DEV(NUM_DEV), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .devRaise  (devRaise),
  .intAck    (intAck),
  .intReq    (intReq),
  .vecData   (vecData),
  .vecValid  (vecValid),
  .tableAddr (tableAddr),
  .spurious  (spurious),
  .devGranted(devGranted)
);

// File: tb/irq_chain_arb_tb.sv
module irq_chain_arb_tb;
  localparam int NUM_DEV = 8;
  localparam int VEC_W   = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_DEV-1:0] devRaise = '0;
  logic               intAck = 1'b0;
  logic               intReq;
  logic [VEC_W-1:0]   vecData;
  logic               vecValid;
  logic [VEC_W+1:0]   tableAddr;
  logic               spurious;
  logic [NUM_DEV-1:0] devGranted;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  logic [VEC_W-1:0] expVec [NUM_DEV];

  always #2 clk = ~clk;

  irq_chain_arb u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .devRaise  (devRaise),
    .intAck    (intAck),
    .intReq    (intReq),
    .vecData   (vecData),
    .vecValid  (vecValid),
    .tableAddr (tableAddr),
    .spurious  (spurious),
    .devGranted(devGranted)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, sample at the next falling edge.
  task automatic step(logic [NUM_DEV-1:0] raise, logic ack);
    devRaise = raise;
    intAck   = ack;
    @(negedge clk);
    devRaise = '0;
    intAck   = 1'b0;
  endtask

  task automatic expectGrant(string req, int slot);
    check(req, "vecValid", 32'(vecValid), 32'd1);
    check(req, "spurious", 32'(spurious), 32'd0);
    check(req, "devGranted", 32'(devGranted), 32'(1 << slot));
    check(req, "vecData", 32'(vecData), 32'(expVec[slot]));
    check("R5", "tableAddr", 32'(tableAddr), 32'(expVec[slot]) * 4);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check("R9", "intReq", 32'(intReq), 0);
    check("R9", "vecData", 32'(vecData), 0);
    check("R9", "vecValid", 32'(vecValid), 0);
    check("R9", "tableAddr", 32'(tableAddr), 0);
    check("R9", "spurious", 32'(spurious), 0);
    check("R9", "devGranted", 32'(devGranted), 0);
  endtask

  task automatic tSingle();
    step(8'h08, 1'b0);
    check("R1", "intReq after raise", 32'(intReq), 1);
    step('0, 1'b0);
    check("R1", "intReq held", 32'(intReq), 1);
    step('0, 1'b1);
    expectGrant("R4", 3);
    check("R3", "intReq cleared", 32'(intReq), 0);
  endtask

  task automatic tPriority();
    step(8'ha4, 1'b0);
    step('0, 1'b1);
    expectGrant("R2", 2);
    check("R3", "others still pending", 32'(intReq), 1);
    step('0, 1'b1);
    expectGrant("R2", 5);
    step('0, 1'b1);
    expectGrant("R2", 7);
    check("R5", "max address", 32'(tableAddr), 32'h3fc);
    check("R3", "all served", 32'(intReq), 0);
  endtask

  task automatic tSpurious();
    step('0, 1'b1);
    check("R6", "spurious", 32'(spurious), 1);
    check("R6", "vecValid", 32'(vecValid), 0);
    check("R6", "devGranted", 32'(devGranted), 0);
    check("R6", "vecData kept", 32'(vecData), 32'hff);
    check("R6", "tableAddr kept", 32'(tableAddr), 32'h3fc);
  endtask

  task automatic tHold();
    step('0, 1'b0);
    check("R8", "vecValid", 32'(vecValid), 0);
    check("R8", "spurious", 32'(spurious), 0);
    check("R8", "devGranted", 32'(devGranted), 0);
    check("R8", "vecData", 32'(vecData), 32'hff);
  endtask

  task automatic tSetWins();
    step(8'h02, 1'b0);
    step(8'h02, 1'b1);
    expectGrant("R7", 1);
    check("R7", "re-raised stays pending", 32'(intReq), 1);
    step('0, 1'b1);
    expectGrant("R7", 1);
    check("R7", "served twice", 32'(intReq), 0);
  endtask

  task automatic tLateHigh();
    step(8'h40, 1'b0);
    step(8'h01, 1'b0);
    step('0, 1'b1);
    expectGrant("R2", 0);
    step('0, 1'b1);
    expectGrant("R2", 6);
    step('0, 1'b0);
    check("R8", "granted clears", 32'(devGranted), 0);
    check("R8", "vecData hold", 32'(vecData), 32'(expVec[6]));
  endtask

  initial begin
    expVec[0] = 8'h05; expVec[1] = 8'h12; expVec[2] = 8'h21; expVec[3] = 8'h33;
    expVec[4] = 8'h40; expVec[5] = 8'h55; expVec[6] = 8'h6a; expVec[7] = 8'hff;
    @(negedge clk);
    tReset();
    tSingle();
    tPriority();
    tSpurious();
    tHold();
    tSetWins();
    tLateHigh();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule